// File: doc/BRIEF.md
# Reset, Watchdog and Sleep Supervisor

This block decides when a small processor core may execute. It holds the core in reset after power is applied for a fixed startup interval. It also resets the core when an enabled external reset pin is pulled low, and when a watchdog counter expires while the core is awake. The core can park itself in a halted sleep state. Sleep ends when any monitored digital input differs from its value at sleep entry, when the comparator output changes, or when the watchdog expires. In each of these cases execution resumes without a reset.

The watchdog counts edges of its own slow tick, not core clock cycles. Only a static configuration bit can turn it off. A clear strobe from the core restarts the count, and so does entering sleep. A set of sticky cause flags tells the core what has happened since power was applied. Only a power-on clears these flags. A configuration bit chooses whether the shared pin is a reset input or a plain digital input. The block reports that choice on an output so the pin logic can route the pin.

Top module: `rstwake_ctrl`

## Requirements
- R1: Configuration word bit 4 = 1 makes the shared pin an active-low reset and drives `rstpin_is_gpio` low. Bit 4 = 0 drives `rstpin_is_gpio` high. Bit 2 = 1 enables the watchdog. All other bits of the word have no effect.
- R2: While `por_n` is low, `core_rst_n` and `core_run` are 0 and `cause_flags` is 6'b000001 (bit 0 = power-on).
- R3: After `por_n` rises, `core_rst_n` stays low for between STARTUP_CYCLES and STARTUP_CYCLES+4 clock cycles. No later reset cause inserts this delay again.
- R4: With bit 4 = 1, a low level on `rst_pin` forces `core_rst_n` low within 4 cycles and keeps it low while the pin stays low. After the pin rises, the core runs again within 4 cycles, and `cause_flags` bit 1 is set.
- R5: With bit 4 = 0, `rst_pin` never resets the core and never sets `cause_flags` bit 1.
- R6: With the watchdog enabled and the core awake, WDT_LIMIT rising edges of `wdt_tick` with no clear in between reset the core for exactly one cycle and set `cause_flags` bit 2.
- R7: A `wdt_clr` pulse, or entry into sleep, restarts the watchdog count from zero.
- R8: With bit 2 = 0, watchdog ticks neither reset the core nor end sleep.
- R9: A `sleep_req` pulse while running drops `core_run` to 0 while `core_rst_n` stays 1. The pin and comparator values at that moment become the wake references.
- R10: In sleep, a change of any `pins_in` bit from its reference resumes execution without a reset and sets `cause_flags` bit 3.
- R11: In sleep, a change of `cmp_in` from its reference resumes execution without a reset and sets `cause_flags` bit 4.
- R12: In sleep, a watchdog expiry resumes execution without a reset and sets `cause_flags` bit 5, not bit 2.
- R13: Bits of `cause_flags` only ever go from 0 to 1, until the next power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| cfg_word | input | 12 | Static configuration word |
| rst_pin | input | 1 | Raw level of the shared reset/input pin |
| wdt_tick | input | 1 | Slow free-running watchdog tick, asynchronous |
| sleep_req | input | 1 | One-cycle request from the core to sleep |
| wdt_clr | input | 1 | One-cycle watchdog clear strobe |
| pins_in | input | NPIN | Monitored digital input pins, asynchronous |
| cmp_in | input | 1 | Comparator output, asynchronous |
| core_rst_n | output | 1 | Core reset, active low |
| core_run | output | 1 | Core execution enable |
| rstpin_is_gpio | output | 1 | 1 when the shared pin is a plain input |
| cause_flags | output | 6 | Sticky cause flags: 0 power-on, 1 external, 2 watchdog reset, 3 pin wake, 4 comparator wake, 5 watchdog wake |

## Verification
The assertions take for granted that the configuration word does not change while `por_n` is high. They also assume that `sleep_req` and `wdt_clr` are single-cycle pulses in the core clock domain. The asynchronous inputs may change at any time. The stimulus changes the configuration only while power-on reset is held. It drives every input half a cycle away from the active edge. It holds each tick level for two core cycles, so every tick edge passes through the synchronizer exactly once.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  localparam int CFG_W        = 12;
  localparam int CFG_XRST_BIT = 4;
  localparam int CFG_WDT_BIT  = 2;

  localparam int STS_W      = 6;
  localparam int STS_POR    = 0;
  localparam int STS_EXT    = 1;
  localparam int STS_WDTRST = 2;
  localparam int STS_WK_PIN = 3;
  localparam int STS_WK_CMP = 4;
  localparam int STS_WK_WDT = 5;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_RUN   = 3'd1,
    ST_SLEEP = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WRST  = 3'd4
  } rwc_state_e;

endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= {W{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rwc_wdt.sv
module rwc_wdt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick_s,
  input  logic clr,
  output logic timeout
);

  localparam int            CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          tick_d_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_ev, at_last;

  assign tick_ev = tick_s & ~tick_d_q;
  assign at_last = (cnt_q == LAST);
  assign timeout = en & tick_ev & at_last & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !en) begin
      cnt_d = '0;
    end else if (tick_ev) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      tick_d_q <= tick_s;
      cnt_q    <= cnt_d;
    end
  end

  AST_WDT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R6
  AST_WDT_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));  // R7
  AST_WDT_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));  // R8

endmodule

// File: rtl/rwc_wake.sv
module rwc_wake #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [NPIN-1:0] pins_s,
  input  logic            cmp_s,
  output logic            pin_chg,
  output logic            cmp_chg
);

  logic [NPIN-1:0] ref_q, ref_d;
  logic            cref_q, cref_d;
  logic [NPIN-1:0] diff;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign diff[i] = pins_s[i] ^ ref_q[i];
    end
  endgenerate

  assign pin_chg = |diff;
  assign cmp_chg = cmp_s ^ cref_q;

  always_comb begin
    ref_d  = ref_q;
    cref_d = cref_q;
    if (arm) begin
      ref_d  = pins_s;
      cref_d = cmp_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      cref_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      cref_q <= cref_d;
    end
  end

  AST_WAKE_REF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (ref_q == $past(pins_s)) && (cref_q == $past(cmp_s)));  // R9

endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
  import rwc_pkg::*;
#(
  parameter int NPIN           = 4,
  parameter int STARTUP_CYCLES = 1000,
  parameter int WDT_LIMIT      = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             rst_pin,
  input  logic             wdt_tick,
  input  logic             sleep_req,
  input  logic             wdt_clr,
  input  logic [NPIN-1:0]  pins_in,
  input  logic             cmp_in,
  output logic             core_rst_n,
  output logic             core_run,
  output logic             rstpin_is_gpio,
  output logic [STS_W-1:0] cause_flags
);

  localparam int            SU_W  = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);
  localparam int            AW    = NPIN + 2;

  // power-on reset: asynchronous assert, synchronous release
  logic por_r1_q, srst_n;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_r1_q <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      por_r1_q <= 1'b1;
      srst_n   <= por_r1_q;
    end
  end

  // configuration decode
  logic xrst_en, wdt_en, cfg_unused;
  assign xrst_en        = cfg_word[CFG_XRST_BIT];
  assign wdt_en         = cfg_word[CFG_WDT_BIT];
  assign rstpin_is_gpio = ~xrst_en;
  assign cfg_unused     = ^{cfg_word[CFG_W-1:CFG_XRST_BIT+1], cfg_word[CFG_XRST_BIT-1:CFG_WDT_BIT+1],
                            cfg_word[CFG_WDT_BIT-1:0]};

  // input synchronizers
  logic [AW-1:0]   async_vec, sync_vec;
  logic [NPIN-1:0] pins_s;
  logic            cmp_s, tick_s, rpin_s;

  assign async_vec = {wdt_tick, cmp_in, pins_in};

  rwc_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_in (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (async_vec),
    .q     (sync_vec)
  );

  rwc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (rst_pin),
    .q     (rpin_s)
  );

  assign pins_s = sync_vec[NPIN-1:0];
  assign cmp_s  = sync_vec[NPIN];
  assign tick_s = sync_vec[NPIN+1];

  // state
  rwc_state_e       state_q, state_d;
  logic [SU_W-1:0]  su_cnt_q, su_cnt_d;
  logic [STS_W-1:0] flags_q, flags_d;

  logic ext_act, awake, asleep, running, su_done;
  logic go_sleep, wdt_clr_i, wdt_to, pin_chg, cmp_chg;
  logic wake_pin, wake_cmp, wake_wdt, wake_any;

  assign ext_act = xrst_en & ~rpin_s;
  assign running = (state_q == ST_RUN);
  assign asleep  = (state_q == ST_SLEEP);
  assign awake   = running | asleep;
  assign su_done = (su_cnt_q == SU_LAST);

  assign go_sleep  = running & sleep_req & ~ext_act & ~wdt_to;
  assign wdt_clr_i = wdt_clr | (running & sleep_req) | ~awake;

  rwc_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (wdt_en),
    .tick_s  (tick_s),
    .clr     (wdt_clr_i),
    .timeout (wdt_to)
  );

  rwc_wake #(.NPIN(NPIN)) u_wake (
    .clk     (clk),
    .rst_n   (srst_n),
    .arm     (go_sleep),
    .pins_s  (pins_s),
    .cmp_s   (cmp_s),
    .pin_chg (pin_chg),
    .cmp_chg (cmp_chg)
  );

  assign wake_pin = asleep & ~ext_act & pin_chg;
  assign wake_cmp = asleep & ~ext_act & cmp_chg;
  assign wake_wdt = asleep & ~ext_act & wdt_to;
  assign wake_any = wake_pin | wake_cmp | wake_wdt;

  // next state
  always_comb begin
    state_d  = state_q;
    su_cnt_d = su_cnt_q;
    case (state_q)
      ST_START: begin
        su_cnt_d = su_cnt_q + 1'b1;
        if (su_done) begin
          su_cnt_d = '0;
          state_d  = ext_act ? ST_HOLD : ST_RUN;
        end
      end
      ST_RUN: begin
        if (ext_act)       state_d = ST_HOLD;
        else if (wdt_to)   state_d = ST_WRST;
        else if (go_sleep) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (ext_act)       state_d = ST_HOLD;
        else if (wake_any) state_d = ST_RUN;
      end
      ST_HOLD: begin
        if (!ext_act)      state_d = ST_RUN;
      end
      ST_WRST: begin
        state_d = ext_act ? ST_HOLD : ST_RUN;
      end
      default: state_d = ST_START;
    endcase
  end

  // cause flags
  always_comb begin
    flags_d = flags_q;
    if (state_d == ST_HOLD && state_q != ST_HOLD) flags_d[STS_EXT]    = 1'b1;
    if (running && wdt_to && !ext_act)            flags_d[STS_WDTRST] = 1'b1;
    if (wake_pin)                                 flags_d[STS_WK_PIN] = 1'b1;
    if (wake_cmp)                                 flags_d[STS_WK_CMP] = 1'b1;
    if (wake_wdt)                                 flags_d[STS_WK_WDT] = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= ST_START;
      su_cnt_q <= '0;
      flags_q  <= STS_W'(1) << STS_POR;
    end else begin
      state_q  <= state_d;
      su_cnt_q <= su_cnt_d;
      flags_q  <= flags_d;
    end
  end

  assign core_rst_n  = awake;
  assign core_run    = running;
  assign cause_flags = flags_q;

  AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (xrst_en && !rpin_s) |=> !core_rst_n);  // R4
  AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!srst_n)
    !xrst_en |=> (state_q != ST_HOLD));  // R5
  AST_NO_RESTART_DELAY: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q != ST_START) |=> (state_q != ST_START));  // R3
  AST_WDT_RUN_RESET: assert property (@(posedge clk) disable iff (!srst_n)
    (running && wdt_to && !ext_act) |=> (!core_rst_n && state_q == ST_WRST));  // R6
  AST_WDT_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!srst_n)
    (asleep && wdt_to && !ext_act) |=> (core_rst_n && core_run));  // R12
  AST_SLEEP_HALTS: assert property (@(posedge clk) disable iff (!srst_n)
    go_sleep |=> (core_rst_n && !core_run));  // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    ((cause_flags & $past(cause_flags)) == $past(cause_flags)));  // R13

endmodule

// File: tb/tb_rstwake_ctrl.sv
module tb_rstwake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NPIN  = 4;
  localparam int SU    = 1000;
  localparam int LIMIT = 8;

  logic             clk;
  logic             por_n;
  logic [11:0]      cfg_word;
  logic             rst_pin, wdt_tick, sleep_req, wdt_clr, cmp_in;
  logic [NPIN-1:0]  pins_in;
  logic             core_rst_n, core_run, rstpin_is_gpio;
  logic [5:0]       cause_flags;

  int checks = 0;
  int errors = 0;
  int low_total = 0;
  bit done = 0;

  rstwake_ctrl #(.NPIN(NPIN), .STARTUP_CYCLES(SU), .WDT_LIMIT(LIMIT), .SYNC_STAGES(2)) dut (
    .clk(clk), .por_n(por_n), .cfg_word(cfg_word), .rst_pin(rst_pin),
    .wdt_tick(wdt_tick), .sleep_req(sleep_req), .wdt_clr(wdt_clr),
    .pins_in(pins_in), .cmp_in(cmp_in), .core_rst_n(core_rst_n),
    .core_run(core_run), .rstpin_is_gpio(rstpin_is_gpio), .cause_flags(cause_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (por_n && !core_rst_n) low_total++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick = 1'b1; wait_n(2);
      wdt_tick = 1'b0; wait_n(2);
    end
    wait_n(2);
  endtask

  task automatic strobe_sleep();
    sleep_req = 1'b1; wait_n(1); sleep_req = 1'b0; wait_n(3);
  endtask

  task automatic do_por(input logic [11:0] cfg);
    int n;
    @(negedge clk);
    por_n = 1'b0; cfg_word = cfg;
    wait_n(3);
    chk("R2", "core_rst_n in reset", core_rst_n, 0);
    chk("R2", "core_run in reset", core_run, 0);
    chk("R2", "flags in reset", cause_flags, 6'b000001);
    por_n = 1'b1;
    n = 0;
    while (!core_rst_n && n < SU + 50) begin @(negedge clk); n++; end
    checks++;
    if (n < SU || n > SU + 4) begin
      errors++;
      $display("FAIL R3 startup length: actual %0d expected %0d..%0d", n, SU, SU + 4);
    end
    chk("R2", "flags after startup", cause_flags, 6'b000001);
    chk("R1", "pin select", rstpin_is_gpio, cfg[4] ? 0 : 1);
  endtask

  task automatic t_wdt_clear_and_sleep_wake();
    int base = low_total;
    pulse_ticks(LIMIT - 1);
    wdt_clr = 1'b1; wait_n(1); wdt_clr = 1'b0; wait_n(1);
    pulse_ticks(LIMIT - 1);
    chk("R7", "no reset after clear", low_total - base, 0);
    chk("R7", "wdt flag after clear", cause_flags[2], 0);
    strobe_sleep();
    chk("R9", "asleep run", core_run, 0);
    chk("R9", "asleep rst_n", core_rst_n, 1);
    pulse_ticks(LIMIT - 1);
    chk("R7", "sleep entry cleared count", core_run, 0);
    pulse_ticks(1);
    chk("R12", "wdt wake run", core_run, 1);
    chk("R12", "wdt wake no reset", low_total - base, 0);
    chk("R12", "wake flag", cause_flags[5], 1);
    chk("R12", "no wdt reset flag", cause_flags[2], 0);
  endtask

  task automatic t_wdt_reset();
    int base = low_total;
    pulse_ticks(LIMIT - 1);
    chk("R6", "no reset before limit", low_total - base, 0);
    pulse_ticks(1);
    chk("R6", "one-cycle reset", low_total - base, 1);
    chk("R6", "running again", core_run, 1);
    chk("R6", "wdt reset flag", cause_flags[2], 1);
  endtask

  task automatic t_wake_pin();
    int base = low_total;
    strobe_sleep();
    wait_n(20);
    chk("R10", "stays asleep", core_run, 0);
    pins_in[2] = ~pins_in[2];
    wait_n(5);
    chk("R10", "pin wake run", core_run, 1);
    chk("R10", "pin wake no reset", low_total - base, 0);
    chk("R10", "pin flag", cause_flags[3], 1);
  endtask

  task automatic t_wake_cmp();
    int base = low_total;
    strobe_sleep();
    wait_n(20);
    chk("R11", "stays asleep", core_run, 0);
    cmp_in = ~cmp_in;
    wait_n(5);
    chk("R11", "cmp wake run", core_run, 1);
    chk("R11", "cmp wake no reset", low_total - base, 0);
    chk("R11", "cmp flag", cause_flags[4], 1);
  endtask

  task automatic t_ext_reset();
    int n;
    rst_pin = 1'b0;
    wait_n(4);
    chk("R4", "reset asserted", core_rst_n, 0);
    chk("R4", "run dropped", core_run, 0);
    wait_n(30);
    chk("R4", "reset held", core_rst_n, 0);
    rst_pin = 1'b1;
    n = 0;
    while (!core_rst_n && n < 50) begin @(negedge clk); n++; end
    checks++;
    if (n > 4) begin
      errors++;
      $display("FAIL R4 release latency: actual %0d expected <=4", n);
    end
    chk("R4", "running after release", core_run, 1);
    chk("R4", "ext flag", cause_flags[1], 1);
  endtask

  task automatic t_sticky();
    chk("R13", "all flags held", cause_flags, 6'h3F);
    wait_n(10);
    chk("R13", "flags still held", cause_flags, 6'h3F);
  endtask

  task automatic t_ext_ignored();
    int base = low_total;
    rst_pin = 1'b0;
    wait_n(20);
    chk("R5", "no reset from pin", low_total - base, 0);
    chk("R5", "still running", core_run, 1);
    chk("R5", "no ext flag", cause_flags[1], 0);
    rst_pin = 1'b1;
    wait_n(2);
  endtask

  task automatic t_wdt_off();
    int base = low_total;
    pulse_ticks(3 * LIMIT);
    chk("R8", "no reset while off", low_total - base, 0);
    chk("R8", "no wdt flag", cause_flags[2], 0);
    strobe_sleep();
    pulse_ticks(3 * LIMIT);
    chk("R8", "no wake while off", core_run, 0);
    chk("R8", "no wake flag", cause_flags[5], 0);
    pins_in[0] = ~pins_in[0];
    wait_n(5);
    chk("R10", "pin wake with junk cfg", core_run, 1);
  endtask

  initial begin
    por_n = 1'b0; cfg_word = 12'hFFF; rst_pin = 1'b1; wdt_tick = 1'b0;
    sleep_req = 1'b0; wdt_clr = 1'b0; pins_in = '0; cmp_in = 1'b0;
    wait_n(2);
    do_por(12'hFFF);
    t_wdt_clear_and_sleep_wake();
    t_wdt_reset();
    t_wake_pin();
    t_wake_cmp();
    t_ext_reset();
    t_sticky();
    do_por(12'hFEB);
    t_ext_ignored();
    t_wdt_off();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule